// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept. The decision uses only the frame's 48-bit destination address. It holds a table of eight exact-match entries. A programmable count splits the table: the lowest-numbered slots match unicast destinations and the remaining slots match multicast destinations. Multicast traffic that does not fit in the table is screened by a 64-bin bitmap. The bitmap is indexed by a 6-bit XOR fold of the address. A copy-all flag turns the filter into a pass-through. Broadcast frames are always kept.

The receive path presents an address together with a one-cycle strobe. One clock later the block returns a strobed verdict: keep or drop, and a 2-bit code giving the reason. Software-side logic programs the table, the bitmap and the mode bits through a one-cycle write port. There is no read-back path.

The control flow has two named states. `ST_IDLE` means no verdict is being presented. `ST_RESULT` means a verdict is on the outputs. The transitions are:
- *accept-strobe* (`da_valid` high) moves either state to `ST_RESULT`.
- *no-strobe* (`da_valid` low) moves either state to `ST_IDLE`.

Back-to-back strobes therefore keep the block in `ST_RESULT`, with a fresh verdict on every cycle.

Top module: `dafilt_top`

## Requirements
- R1: After reset, every table slot is invalid, the bitmap is all zero, copy-all is off and the unicast count is 0. While reset is held, `dec_valid`, `dec_accept` and `dec_reason` are 0. After reset, every non-broadcast address is dropped.
- R2: A verdict appears exactly one clock after each cycle in which `da_valid` is high, with `dec_valid` high for that one cycle. In cycles with no verdict, `dec_accept` and `dec_reason` are 0. Strobes on consecutive cycles give verdicts on consecutive cycles.
- R3: Address byte k is `da_addr[8k+7:8k]`. Slot i is programmed through two write addresses. Address 2i takes `da_addr[31:0]` (bytes 3..0). Address 2i+1 takes bytes 5,4 in `cfg_wdata[15:0]`. A slot becomes valid only when its upper word is written. An exact match compares all 48 bits and gives reason 1 (exact).
- R4: A frame is multicast when `da_addr[0]` is 1. With unicast count U, slots 0..U-1 match only unicast frames and slots U..7 match only multicast frames.
- R5: The hash index h is 6 bits wide. Bit j of h is the XOR of address bits n with n mod 6 = j, where n runs over `da_addr` from bit 0 to bit 47.
- R6: Bitmap bins 0..31 are written at address 16 (bin b in bit b). Bins 32..63 are written at address 17 (bin b in bit b-32). A multicast frame with no exact match whose bin is set is kept with reason 2 (hash). Unicast frames never consult the bitmap.
- R7: A bitmap of all ones keeps every multicast frame.
- R8: The all-ones address is always kept with reason 1, even with an empty table.
- R9: With copy-all on, every frame is kept. The reason is 3 (promiscuous) when neither an exact match nor the bitmap would keep the frame.
- R10: The mode word is at address 18. Bit 0 is copy-all and bits 7:4 are the unicast count. A write whose count exceeds 8 is discarded whole, so both fields keep their old values.
- R11: Reason priority is exact (1), then hash (2), then promiscuous (3). Reason 0 means dropped, and `dec_accept` is high exactly when the reason is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 5 | Word address: slots 0..15, bitmap 16..17, mode 18 |
| cfg_wdata | input | 32 | Write data |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_valid | output | 1 | Verdict strobe, one cycle after `da_valid` |
| dec_accept | output | 1 | Frame is kept |
| dec_reason | output | 2 | 0 drop, 1 exact, 2 hash, 3 promiscuous |

## Verification
The bench targets the following corner cases:
- **Slot ownership.** The bench moves the unicast count across a programmed slot and checks that the slot changes ownership. A design that ignored the count would keep a multicast address sitting in a unicast slot.
- **Bitmap word split.** The bench picks addresses that hash into each bitmap word and into a neighbouring bin. A design with a misplaced word or an off-by-one fold would keep the wrong frames.
- **Half-written slots and upper bytes.** A slot whose upper word was never written is probed, and so is an address that differs only in its upper bytes. A design that set valid on the lower word, or compared only 32 bits, would keep these frames.
- **Rejected mode write.** A mode write with a count above 8 is checked to leave copy-all untouched. A design that applied part of the write would be caught.
- **Overlapping reasons.** The bench sets up exact, hash and copy-all together to confirm the reason priority.

// File: rtl/dafilt_pkg.sv
`timescale 1ns/1ps
package dafilt_pkg;
    typedef enum logic [1:0] {
        RSN_REJECT  = 2'd0,
        RSN_EXACT   = 2'd1,
        RSN_HASH    = 2'd2,
        RSN_PROMISC = 2'd3
    } reason_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } dstate_e;
endpackage

// File: rtl/dafilt_hash.sv
`timescale 1ns/1ps
// Folds every address bit into a short index, bit n going to index bit n mod HASH_W.
module dafilt_hash #(
    parameter int ADDR_W = 48,
    parameter int HASH_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [HASH_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int n = 0; n < ADDR_W; n++) begin
            idx[n % HASH_W] = idx[n % HASH_W] ^ addr[n];
        end
    end
endmodule

// File: rtl/dafilt_exact.sv
`timescale 1ns/1ps
// Exact-match table with a unicast/multicast split chosen by ucnt.
module dafilt_exact #(
    parameter int N_ENTRY = 8,
    parameter int ADDR_W  = 48,
    parameter int WORD_W  = 32,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_ENTRY-1:0] we_lo,
    input  logic [N_ENTRY-1:0] we_hi,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [CNT_W-1:0]   ucnt,
    input  logic [ADDR_W-1:0]  look_addr,
    output logic               hit
);
    localparam int HI_W = ADDR_W - WORD_W;

    logic [N_ENTRY-1:0] match;
    logic               look_mcast;

    assign look_mcast = look_addr[0];

    for (genvar i = 0; i < N_ENTRY; i++) begin : g_slot
        logic [WORD_W-1:0] lo_q;
        logic [HI_W-1:0]   hi_q;
        logic              val_q;
        logic              uni_slot;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q  <= '0;
                hi_q  <= '0;
                val_q <= 1'b0;
            end else begin
                if (we_lo[i]) lo_q <= wdata;
                if (we_hi[i]) begin
                    hi_q  <= wdata[HI_W-1:0];
                    val_q <= 1'b1;
                end
            end
        end

        assign uni_slot = CNT_W'(i) < ucnt;
        assign match[i] = val_q && ({hi_q, lo_q} == look_addr)
                          && (uni_slot ? !look_mcast : look_mcast);
    end

    assign hit = |match;
endmodule

// File: rtl/dafilt_top.sv
`timescale 1ns/1ps
module dafilt_top #(
    parameter int N_ENTRY = 8,
    parameter int ADDR_W  = 48,
    parameter int HASH_W  = 6,
    parameter int WORD_W  = 32,
    parameter int CFG_AW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              da_valid,
    input  logic [ADDR_W-1:0] da_addr,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [1:0]        dec_reason
);
    import dafilt_pkg::*;

    localparam int CNT_W      = $clog2(N_ENTRY + 1);
    localparam int HASH_BINS  = 1 << HASH_W;
    localparam int HASH_WORDS = HASH_BINS / WORD_W;
    localparam int HASH_BASE  = 2 * N_ENTRY;
    localparam int CTRL_ADDR  = HASH_BASE + HASH_WORDS;
    localparam int UCNT_LSB   = 4;

    // Configuration decode
    logic [N_ENTRY-1:0]   we_lo, we_hi;
    logic [HASH_BINS-1:0] hash_map;
    logic                 copy_all;
    logic [CNT_W-1:0]     ucnt;
    logic [CNT_W-1:0]     wr_cnt;

    for (genvar i = 0; i < N_ENTRY; i++) begin : g_dec
        assign we_lo[i] = cfg_we && (cfg_addr == CFG_AW'(2 * i));
        assign we_hi[i] = cfg_we && (cfg_addr == CFG_AW'(2 * i + 1));
    end

    for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hword
        always_ff @(posedge clk) begin
            if (!rst_n)
                hash_map[w*WORD_W +: WORD_W] <= '0;
            else if (cfg_we && cfg_addr == CFG_AW'(HASH_BASE + w))
                hash_map[w*WORD_W +: WORD_W] <= cfg_wdata;
        end
    end

    assign wr_cnt = cfg_wdata[UCNT_LSB +: CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            copy_all <= 1'b0;
            ucnt     <= '0;
        end else if (cfg_we && cfg_addr == CFG_AW'(CTRL_ADDR)
                     && wr_cnt <= CNT_W'(N_ENTRY)) begin
            copy_all <= cfg_wdata[0];
            ucnt     <= wr_cnt;
        end
    end

    // Lookup
    logic              exact_hit;
    logic [HASH_W-1:0] hidx;
    logic              is_mcast, is_bcast, hash_hit;
    reason_e           rsn_d, rsn_q;
    dstate_e           state_q, state_d;

    dafilt_exact #(
        .N_ENTRY(N_ENTRY), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CNT_W(CNT_W)
    ) u_exact (
        .clk(clk), .rst_n(rst_n), .we_lo(we_lo), .we_hi(we_hi),
        .wdata(cfg_wdata), .ucnt(ucnt), .look_addr(da_addr), .hit(exact_hit)
    );

    dafilt_hash #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_hash (
        .addr(da_addr), .idx(hidx)
    );

    assign is_mcast = da_addr[0];
    assign is_bcast = &da_addr;
    assign hash_hit = is_mcast && hash_map[hidx];

    always_comb begin
        if (exact_hit || is_bcast) rsn_d = RSN_EXACT;
        else if (hash_hit)         rsn_d = RSN_HASH;
        else if (copy_all)         rsn_d = RSN_PROMISC;
        else                       rsn_d = RSN_REJECT;
    end

    // Next state
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = da_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = da_valid ? ST_RESULT : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rsn_q   <= RSN_REJECT;
        end else begin
            state_q <= state_d;
            rsn_q   <= da_valid ? rsn_d : RSN_REJECT;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                dec_valid  = 1'b0;
                dec_accept = 1'b0;
                dec_reason = RSN_REJECT;
            end
            ST_RESULT: begin
                dec_valid  = 1'b1;
                dec_accept = (rsn_q != RSN_REJECT);
                dec_reason = rsn_q;
            end
        endcase
    end
endmodule

// File: rtl/dafilt_chk.sv
`timescale 1ns/1ps
module dafilt_chk #(
    parameter int ADDR_W  = 48,
    parameter int CNT_W   = 4,
    parameter int N_ENTRY = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              da_valid,
    input logic [ADDR_W-1:0] da_addr,
    input logic              dec_valid,
    input logic              dec_accept,
    input logic [1:0]        dec_reason,
    input logic              copy_all,
    input logic [CNT_W-1:0]  ucnt
);
    a_r2_follows: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> dec_valid);
    a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> !dec_valid);
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_accept && dec_reason == 2'd0));
    a_r8_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && &da_addr) |=> (dec_accept && dec_reason == 2'd1));
    a_r6_unicast_no_hash: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && !da_addr[0]) |=> (dec_reason != 2'd2));
    a_r9_promisc_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && copy_all) |=> dec_accept);
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ucnt <= CNT_W'(N_ENTRY));
endmodule

bind dafilt_top dafilt_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .N_ENTRY(N_ENTRY)) u_chk (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_addr(da_addr),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason),
    .copy_all(copy_all), .ucnt(ucnt)
);

// File: tb/dafilt_top_bench.sv
`timescale 1ns/1ps
module dafilt_top_bench;
    localparam int N = 8;
    localparam logic [1:0] REJ = 2'd0, EXA = 2'd1, HSH = 2'd2, PRM = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da_addr = '0;
    logic        dec_valid, dec_accept;
    logic [1:0]  dec_reason;

    always #2 clk = ~clk;

    dafilt_top u_dafilt_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da_addr(da_addr),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // Bench model of programmed state
    logic [31:0] m_lo [N];
    logic [15:0] m_hi [N];
    logic        m_val [N];
    logic [63:0] m_hash;
    logic        m_copy;
    int          m_ucnt;

    function automatic logic [5:0] f_hash(logic [47:0] a);
        logic [5:0] h = '0;
        for (int n = 0; n < 48; n++) h[n % 6] ^= a[n];
        return h;
    endfunction

    function automatic logic [1:0] f_exp(logic [47:0] a);
        if (&a) return EXA;
        for (int i = 0; i < N; i++)
            if (m_val[i] && {m_hi[i], m_lo[i]} == a && ((i < m_ucnt) ? !a[0] : a[0]))
                return EXA;
        if (a[0] && m_hash[f_hash(a)]) return HSH;
        if (m_copy) return PRM;
        return REJ;
    endfunction

    function automatic logic [47:0] rnd48();
        return 48'({$urandom(), $urandom()});
    endfunction

    // Multicast address whose hash index equals h
    function automatic logic [47:0] mk_mc(logic [5:0] h);
        logic [47:0] a = rnd48() | 48'd1;
        logic [5:0] d = f_hash(a) ^ h;
        for (int j = 0; j < 6; j++) if (d[j]) a[j+6] = ~a[j+6];
        return a;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 2 * N) begin
            if (a % 2 == 1) begin m_hi[a/2] = d[15:0]; m_val[a/2] = 1'b1; end
            else m_lo[a/2] = d;
        end else if (a == 16) m_hash[31:0] = d;
        else if (a == 17) m_hash[63:32] = d;
        else if (a == 18 && d[7:4] <= 4'd8) begin m_copy = d[0]; m_ucnt = int'(d[7:4]); end
    endtask

    task automatic set_entry(int i, logic [47:0] a);
        wr(2 * i, a[31:0]);
        wr(2 * i + 1, {16'h0, a[47:32]});
    endtask

    task automatic set_ctrl(int cnt, logic cp);
        wr(18, {24'h0, 4'(cnt), 3'b0, cp});
    endtask

    task automatic set_hash(logic [63:0] h);
        wr(16, h[31:0]);
        wr(17, h[63:32]);
    endtask

    task automatic look(logic [47:0] a, logic [1:0] exp, string tag);
        @(negedge clk);
        da_valid = 1'b1; da_addr = a;
        @(negedge clk);
        da_valid = 1'b0;
        chk({tag, " valid"}, 32'(dec_valid), 32'd1);
        chk(tag, {29'h0, dec_accept, dec_reason}, {29'h0, exp != REJ, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] sta, ma, mh, mh2, uh, ml, a0, a1;
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_val[i] = 1'b0; end
        m_hash = '0; m_copy = 1'b0; m_ucnt = 0;

        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(dec_valid), 0);
        chk("R1 reset outputs", {30'h0, dec_accept, dec_reason[1]} | 32'(dec_reason[0]), 0);
        rst_n = 1'b1;
        look(rnd48() & ~48'd1, REJ, "R1 unicast after reset");
        look(rnd48() | 48'd1, REJ, "R1 multicast after reset");
        look({48{1'b1}}, EXA, "R8 broadcast empty table");

        // R3 / R4 exact table
        sta = rnd48() & ~48'd1;
        set_entry(0, sta);
        look(sta, REJ, "R4 unicast in multicast slot");
        set_ctrl(1, 1'b0);
        look(sta, EXA, "R3 station match");
        look(sta ^ 48'h8000_0000_0000, REJ, "R3 upper byte differs");
        ml = {16'h0, $urandom() | 32'd1};
        wr(6, ml[31:0]);
        look(ml, REJ, "R3 lower word only not valid");
        wr(7, 32'h0);
        look(ml, EXA, "R3 slot valid after upper write");
        ma = rnd48() | 48'd1;
        set_entry(1, ma);
        look(ma, EXA, "R4 multicast slot match");
        set_ctrl(2, 1'b0);
        look(ma, REJ, "R4 slot now unicast");
        look(sta, EXA, "R4 station still unicast");
        set_ctrl(1, 1'b0);

        // R2 back-to-back strobes then idle
        @(negedge clk); da_valid = 1'b1; da_addr = sta;
        @(negedge clk); da_addr = rnd48() & ~48'd1;
        chk("R2 first of pair", {30'h0, dec_valid, dec_reason == EXA}, 32'd3);
        @(negedge clk); da_valid = 1'b0;
        chk("R2 second of pair", {29'h0, dec_valid, dec_reason}, {29'h0, 1'b1, REJ});
        @(negedge clk);
        chk("R2 idle after pair", {30'h0, dec_valid, dec_accept}, 32'd0);

        // R5 / R6 hash
        mh = mk_mc(6'd37);
        chk("R5 hash fold", 32'(f_hash(mh)), 32'd37);
        set_hash(64'h1 << 37);
        look(mh, HSH, "R6 high word bin");
        mh2 = mk_mc(6'd5);
        set_hash(64'h1 << 5);
        look(mh2, HSH, "R6 low word bin");
        look(mh, REJ, "R6 other word clear");
        set_hash(64'h1 << 6);
        look(mh2, REJ, "R5 neighbour bin");
        uh = mh2 & ~48'd1;
        set_hash(64'h1 << f_hash(uh));
        look(uh, REJ, "R6 unicast ignores bitmap");

        // R7 all-ones bitmap
        set_hash({64{1'b1}});
        for (int k = 0; k < 4; k++) look(rnd48() | 48'd1, HSH, "R7 any multicast");
        look(rnd48() & ~48'd1, REJ, "R7 unicast still dropped");
        look(ma, EXA, "R11 exact over hash");

        // R9 copy-all
        set_ctrl(1, 1'b1);
        look(rnd48() & ~48'd1, PRM, "R9 promiscuous unicast");
        look(mh, HSH, "R11 hash over promiscuous");
        set_hash(64'h0);
        look(rnd48() | 48'd1, PRM, "R9 promiscuous multicast");
        look(sta, EXA, "R11 exact over promiscuous");

        // R10 mode write guard
        set_ctrl(9, 1'b0);
        look(rnd48() & ~48'd1, PRM, "R10 count 9 discarded");
        set_ctrl(0, 1'b0);
        look(sta, REJ, "R10 count 0 accepted");
        set_ctrl(15, 1'b1);
        look(rnd48() & ~48'd1, REJ, "R10 count 15 discarded");

        // Random configurations
        for (int r = 0; r < 40; r++) begin
            for (int i = 0; i < N; i++) begin
                a0 = rnd48();
                a0[0] = ($urandom() % 2) == 0;
                set_entry(i, a0);
            end
            set_ctrl(int'($urandom() % 9), ($urandom() % 4) == 0);
            set_hash(64'({$urandom(), $urandom()}) & 64'({$urandom(), $urandom()}));
            for (int k = 0; k < 15; k++) begin
                case ($urandom() % 4)
                    0: a1 = {m_hi[$urandom() % N], m_lo[$urandom() % N]};
                    1: begin
                        int s = int'($urandom() % N);
                        a1 = {m_hi[s], m_lo[s]};
                        if (($urandom() % 3) == 0) a1[0] = ~a1[0];
                    end
                    2: a1 = ($urandom() % 5 == 0) ? {48{1'b1}} : rnd48();
                    default: a1 = rnd48() | 48'd1;
                endcase
                look(a1, f_exp(a1), "R11 random lookup");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule